// File: doc/BRIEF.md
# Shifted-Add Address Generator

This block forms array-element addresses for an integer pipeline of width XLEN (32 or 64). It takes a base operand, an index operand, a 6-bit immediate shift count and a 3-bit operation code. It scales one operand by a small power of two and adds the other, all in a single adder pass. The sum is registered, so the result appears one clock after its inputs are sampled.

When XLEN is 64, a second family of operations first zero-extends the low 32 bits of the first operand. This lets a 32-bit unsigned index be scaled and added to a 64-bit base without a separate extension step. The same family includes an immediate left shift of that zero-extended word. With XLEN at 32 these word forms do not exist: selecting one raises an illegal flag and returns zero.

Top module: `shadd_agu`

## Requirements
- R1: A synchronous active-high `rst` clears `result_o` and `illegal_o` to zero at the next rising clock edge.
- R2: Outputs are registered. Inputs sampled at a rising edge appear on `result_o`/`illegal_o` after that edge, and the outputs hold their previous value until then.
- R3: Op codes 5, 6 and 7 (op[2]=1, op[1:0]=N for N=1,2,3) give `(rs1 << N) + rs2` modulo 2^XLEN.
- R4: Op code 0 (XLEN=64) gives the zero-extended `rs1[31:0]` plus `rs2`, modulo 2^64.
- R5: Op codes 1, 2 and 3 (XLEN=64, N=op[1:0]) give the zero-extended `rs1[31:0]` shifted left by N, plus `rs2`, modulo 2^64.
- R6: Op code 4 (XLEN=64) gives the zero-extended `rs1[31:0]` shifted left by `imm_shamt_i` (0 to 63). Bits beyond bit 63 are dropped and `rs2` has no effect.
- R7: With XLEN=32, op codes 0 to 4 set `illegal_o`=1 and `result_o`=0. Op codes 5 to 7 and every op code at XLEN=64 leave `illegal_o`=0.
- R8: For op codes 0 to 4, bits 63:32 of `rs1` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rs1_i | input | XLEN | Operand that is scaled (and zero-extended for word forms) |
| rs2_i | input | XLEN | Operand that is added |
| imm_shamt_i | input | 6 | Shift count for op code 4 |
| op_i | input | 3 | Operation code (see R3 to R7) |
| result_o | output | XLEN | Registered result |
| illegal_o | output | 1 | Registered flag: word form selected at XLEN=32 |

## Verification
Operands with all ones in the upper word separate a correct zero-extension from a sign-extension or pass-through. Sums that carry past bit XLEN-1 show that the result wraps rather than saturating. Shift counts of 0, 40 and 63 on the immediate form show where bits fall off the top. Random operands, half of them with the upper word forced to ones, compare every op code against a multiply-based reference model. A 32-bit instance shows that the word forms are flagged while the scaled adds still wrap at 32 bits.

// File: rtl/shadd_agu_pkg.sv
package shadd_agu_pkg;
  typedef enum logic [2:0] {
    OP_ADD_UW    = 3'd0,
    OP_SH1ADD_UW = 3'd1,
    OP_SH2ADD_UW = 3'd2,
    OP_SH3ADD_UW = 3'd3,
    OP_SLLI_UW   = 3'd4,
    OP_SH1ADD    = 3'd5,
    OP_SH2ADD    = 3'd6,
    OP_SH3ADD    = 3'd7
  } agu_op_e;

  localparam int SHAMT_W = 6;
  localparam int WORD_W  = 32;
endpackage

// File: rtl/agu_src_prep.sv
module agu_src_prep #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rs1_i,
  input  logic            uw_i,
  output logic [XLEN-1:0] opnd_o
);
  import shadd_agu_pkg::*;

  generate
    if (XLEN > WORD_W) begin : g_wide
      logic [XLEN-1:0] zx;
      assign zx     = {{(XLEN-WORD_W){1'b0}}, rs1_i[WORD_W-1:0]};
      assign opnd_o = uw_i ? zx : rs1_i;
    end else begin : g_narrow
      // no word forms at this width; the flag path zeroes the result
      assign opnd_o = rs1_i;
    end
  endgenerate
endmodule

// File: rtl/agu_shift.sv
module agu_shift #(
  parameter int XLEN = 64,
  parameter int AMT_W = 6
) (
  input  logic [XLEN-1:0]  opnd_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [XLEN-1:0]  shifted_o
);
  assign shifted_o = opnd_i << amt_i;
endmodule

// File: rtl/agu_add.sv
module agu_add #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            b_en_i,
  output logic [XLEN-1:0] sum_o
);
  logic [XLEN-1:0] b_g;
  assign b_g   = b_en_i ? b_i : '0;
  assign sum_o = a_i + b_g;
endmodule

// File: rtl/shadd_agu.sv
module shadd_agu #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [5:0]      imm_shamt_i,
  input  logic [2:0]      op_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  import shadd_agu_pkg::*;

  localparam bit HAS_UW = (XLEN == 64);

  agu_op_e          op;
  logic             uw_form;
  logic             is_slli;
  logic             illegal_c;
  logic [SHAMT_W-1:0] amt;
  logic [XLEN-1:0]  opnd;
  logic [XLEN-1:0]  shifted;
  logic [XLEN-1:0]  sum;
  logic [XLEN-1:0]  result_q;
  logic             illegal_q;

  assign op        = agu_op_e'(op_i);
  assign is_slli   = (op == OP_SLLI_UW);
  assign uw_form   = (op_i <= 3'(OP_SLLI_UW));
  assign illegal_c = uw_form && !HAS_UW;
  assign amt       = is_slli ? imm_shamt_i : {{(SHAMT_W-2){1'b0}}, op_i[1:0]};

  agu_src_prep #(.XLEN(XLEN)) u_prep (
    .rs1_i  (rs1_i),
    .uw_i   (uw_form),
    .opnd_o (opnd)
  );

  agu_shift #(.XLEN(XLEN), .AMT_W(SHAMT_W)) u_shift (
    .opnd_i    (opnd),
    .amt_i     (amt),
    .shifted_o (shifted)
  );

  agu_add #(.XLEN(XLEN)) u_add (
    .a_i    (shifted),
    .b_i    (rs2_i),
    .b_en_i (!is_slli),
    .sum_o  (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q  <= '0;
      illegal_q <= 1'b0;
    end else begin
      result_q  <= illegal_c ? '0 : sum;
      illegal_q <= illegal_c;
    end
  end

  assign result_o  = result_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/shadd_agu_chk.sv
module shadd_agu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic [5:0]      imm_shamt_i,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o
);
  localparam bit WIDE = (XLEN == 64);

  logic [XLEN-1:0] low_word;
  assign low_word = XLEN'({32'd0, rs1_i[31:0]});

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (result_o == '0 && !illegal_o));

  // R3
  scaled_add_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i[2] && op_i[1:0] != 2'd0) |=> (result_o == $past((rs1_i << op_i[1:0]) + rs2_i)));

  // R5
  word_scaled_add_chk: assert property (@(posedge clk) disable iff (rst)
    (WIDE && !op_i[2]) |=> (result_o == $past((low_word << op_i[1:0]) + rs2_i)));

  // R6
  word_imm_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (WIDE && op_i == 3'd4) |=> (result_o == $past(low_word << imm_shamt_i)));

  // R7
  illegal_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!WIDE && op_i <= 3'd4) |=> (illegal_o && result_o == '0));

  // R7
  illegal_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (WIDE || op_i > 3'd4) |=> !illegal_o);
endmodule

bind shadd_agu shadd_agu_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rs1_i       (rs1_i),
  .rs2_i       (rs2_i),
  .imm_shamt_i (imm_shamt_i),
  .op_i        (op_i),
  .result_o    (result_o),
  .illegal_o   (illegal_o)
);

// File: tb/test_shadd_agu.sv
module test_shadd_agu;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  localparam logic [2:0] T_OP [NV] = '{3'd7, 3'd5, 3'd6, 3'd0, 3'd1, 3'd3, 3'd4, 3'd4, 3'd4, 3'd2};
  localparam logic [63:0] T_A [NV] = '{
    64'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_0000_0010,
    64'hDEAD_BEEF_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'h0000_0001_4000_0000};
  localparam logic [63:0] T_B [NV] = '{
    64'h5, 64'h3, 64'h0, 64'h100, 64'h1, 64'h0, 64'hAA, 64'h0, 64'h77, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [5:0] T_IMM [NV] = '{6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd63, 6'd40, 6'd0, 6'd0};
  localparam logic [63:0] T_EXP [NV] = '{
    64'h85, 64'h1, 64'h4, 64'h110, 64'h1_0000_0001, 64'h7_FFFF_FFF8,
    64'h8000_0000_0000_0000, 64'hFFFF_FF00_0000_0000, 64'h9ABC_DEF0, 64'hFFFF_FFFF};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] rs1 = '0;
  logic [63:0] rs2 = '0;
  logic [5:0]  imm = '0;
  logic [2:0]  op  = '0;
  logic [63:0] res64;
  logic        ill64;
  logic [31:0] res32;
  logic        ill32;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadd_agu #(.XLEN(64)) i_shadd_agu (
    .clk(clk), .rst(rst), .rs1_i(rs1), .rs2_i(rs2), .imm_shamt_i(imm),
    .op_i(op), .result_o(res64), .illegal_o(ill64));

  shadd_agu #(.XLEN(32)) i_shadd_agu_w32 (
    .clk(clk), .rst(rst), .rs1_i(rs1[31:0]), .rs2_i(rs2[31:0]), .imm_shamt_i(imm),
    .op_i(op), .result_o(res32), .illegal_o(ill32));

  function automatic logic [63:0] model(input logic [2:0] o, input logic [63:0] a,
                                        input logic [63:0] b, input logic [5:0] s);
    logic [127:0] w;
    logic [127:0] za;
    za = {96'd0, a[31:0]};
    if (o >= 3'd5)      w = {64'd0, a} * (128'd1 << o[1:0]) + {64'd0, b};
    else if (o == 3'd4) w = za * (128'd1 << s);
    else                w = za * (128'd1 << o[1:0]) + {64'd0, b};
    return w[63:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic [5:0] s);
    @(negedge clk);
    op = o; rs1 = a; rs2 = b; imm = s;
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic [2:0] o);
    if (o >= 3'd5) return "R3";
    if (o == 3'd0) return "R4";
    if (o == 3'd4) return "R6";
    return "R5";
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] prev;
    // R1: reset with nonzero inputs present
    op = 3'd7; rs1 = 64'h55; rs2 = 64'h66;
    repeat (2) @(negedge clk);
    chk("R1 result", res64, 64'd0);
    chk("R1 illegal", {63'd0, ill64}, 64'd0);
    chk("R1 w32 illegal", {63'd0, ill32}, 64'd0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(T_OP[i], T_A[i], T_B[i], T_IMM[i]);
      chk(tag_of(T_OP[i]), res64, T_EXP[i]);
      chk("R7 wide never illegal", {63'd0, ill64}, 64'd0);
    end

    // R2: output holds until the sampling edge
    drive(3'd5, 64'h100, 64'h1, 6'd0);
    prev = res64;
    @(negedge clk);
    op = 3'd7; rs1 = 64'h2; rs2 = 64'h3;
    #1;
    chk("R2 hold before edge", res64, prev);
    @(negedge clk);
    chk("R2 after edge", res64, 64'h13);

    // R8: upper word of rs1 has no effect on word forms
    for (int o = 0; o < 5; o++) begin
      drive(3'(o), 64'h0000_0000_8765_4321, 64'h1000, 6'd12);
      prev = res64;
      drive(3'(o), 64'hFFFF_FFFF_8765_4321, 64'h1000, 6'd12);
      chk("R8 upper ignored", res64, prev);
    end

    // R6: rs2 ignored for immediate shift
    drive(3'd4, 64'h3, 64'hFFFF_0000_FFFF_0000, 6'd4);
    chk("R6 rs2 ignored", res64, 64'h30);

    // R7 on the 32-bit instance
    for (int o = 0; o < 8; o++) begin
      logic [31:0] e32;
      drive(3'(o), 64'hFFFF_FFFF, 64'h5, 6'd3);
      case (o)
        5: e32 = 32'h3;
        6: e32 = 32'h1;
        7: e32 = 32'hFFFF_FFFD;
        default: e32 = 32'h0;
      endcase
      chk("R7 w32 result", {32'd0, res32}, {32'd0, e32});
      chk("R7 w32 illegal", {63'd0, ill32}, {63'd0, (o <= 4)});
    end

    // random sweep with upper word forced to ones half the time
    for (int k = 0; k < 300; k++) begin
      logic [63:0] a, b;
      logic [2:0] o;
      logic [5:0] s;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      o = 3'($urandom);
      s = 6'($urandom);
      if (k[0]) a[63:32] = 32'hFFFF_FFFF;
      drive(o, a, b, s);
      chk(k[0] ? "R8 random" : tag_of(o), res64, model(o, a, b, s));
    end

    // R1: reset after activity
    drive(3'd7, 64'hABC, 64'h1, 6'd0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run result", res64, 64'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule